// File: doc/BRIEF.md
# Counter-Mode Keystream Controller

This block wraps an external 128-bit block-cipher encrypt engine so that it acts as a keystream source. For every 128-bit word taken from an input FIFO, the block sends its current counter block to the engine. It XORs the engine result with the word and pushes the sum to an output FIFO. It then advances the counter block. Encryption and decryption are the same operation here, so the direction input has no effect on any output.

Software writes the initial counter block while the block is disabled and then raises `enable`. The current counter block is always visible on `ctr_value`. A stream can be paused by dropping `enable`, and it can be resumed later by writing back the value read from `ctr_value`. Only the low 32 bits of the counter block count, and they wrap on their own.

The FIFOs are assumed show-ahead: `in_data` is valid whenever `in_empty` is low, and a one-cycle `in_pop` removes the head word. The output FIFO takes `out_data` in any cycle where `out_push` is high. Nothing else writes to the output FIFO.

Top module: `ctr_keystream_ctrl`

## Requirements
- R1: Every output word equals E(counter block used for it) XOR the input word popped for it. E is the engine's result for that counter block.
- R2: The first block after a load sends exactly the loaded 128-bit value to the engine on `eng_in` while `eng_start` is high.
- R3: After each output word is pushed, bits [31:0] of `ctr_value` increase by one. This takes effect in the cycle after the `out_push` pulse.
- R4: Bits [31:0] wrap from 0xFFFFFFFF to 0. Bits [127:32] never change because of an increment.
- R5: The `dir_decrypt` input has no effect. The same input and counter give the same output for either value of `dir_decrypt`.
- R6: A block starts only when `enable` is 1, `in_empty` is 0 and `out_full` is 0 on the previous clock edge. Each start gives one `in_pop` pulse and one `eng_start` pulse in the same cycle.
- R7: `ctr_value` changes only through an increment after a push or through a load. Writing back a value read from `ctr_value` resumes the stream exactly where it stopped.
- R8: `ctr_load_en` is ignored while `enable` is 1 or a block is in flight.
- R9: A synchronous `rst` clears `ctr_value` to zero and drives `out_push`, `in_pop` and `eng_start` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new blocks to start |
| dir_decrypt | input | 1 | Direction setting, has no effect |
| ctr_load_en | input | 1 | Load `ctr_load_val` into the counter block |
| ctr_load_val | input | 128 | Initial or resumed counter block |
| ctr_value | output | 128 | Current counter block (readback) |
| in_empty | input | 1 | Input FIFO has no word |
| in_data | input | 128 | Head word of the input FIFO |
| in_pop | output | 1 | Remove the head word of the input FIFO |
| out_full | input | 1 | Output FIFO has no space |
| out_push | output | 1 | Write `out_data` into the output FIFO |
| out_data | output | 128 | Keystream XOR input word |
| eng_start | output | 1 | Start one encryption of `eng_in` |
| eng_in | output | 128 | Counter block sent to the engine |
| eng_done | input | 1 | Engine result is valid this cycle |
| eng_out | input | 128 | Engine result |

## Verification
A table of input words is sent through the block. The `dir_decrypt` bit alternates from row to row, which separates a correct XOR with the right keystream word from a path that reacts to direction or reuses a stale counter. A counter that starts near the 32-bit boundary shows whether the wrap carries into the upper 96 bits. Stalls with a full output FIFO, an empty input FIFO or a low `enable` show whether blocks start only under the three conditions together. A load attempted while enabled checks that it is ignored. A save, foreign load and write-back sequence checks that a paused stream resumes with the same keystream.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PUSH = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ctr_block_reg.sv
module ctr_block_reg #(
  parameter int BLK_W = 128,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BLK_W-1:0] load_val,
  input  logic             inc,
  output logic [BLK_W-1:0] value
);
  localparam int HI_W = BLK_W - CNT_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val[CNT_W-1:0];
    else if (inc)  cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  generate
    if (HI_W > 0) begin : g_fixed_hi
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk) begin
        if (rst)       hi_q <= '0;
        else if (load) hi_q <= load_val[BLK_W-1:CNT_W];
      end
      assign value = {hi_q, cnt_q};
    end else begin : g_all_count
      assign value = cnt_q;
    end
  endgenerate
endmodule

// File: rtl/ctr_seq.sv
module ctr_seq
  import ctr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic in_empty,
  input  logic out_full,
  input  logic eng_done,
  output logic capture,
  output logic finish,
  output logic in_pop,
  output logic eng_start,
  output logic ctr_inc,
  output logic busy
);
  seq_state_t state_q;

  assign capture = (state_q == ST_IDLE) && enable && !in_empty && !out_full;
  assign finish  = (state_q == ST_WAIT) && eng_done;
  assign ctr_inc = (state_q == ST_PUSH);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      in_pop    <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      in_pop    <= capture;
      eng_start <= capture;
      case (state_q)
        ST_IDLE: if (capture) state_q <= ST_WAIT;
        ST_WAIT: if (eng_done) state_q <= ST_PUSH;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // in_pop and eng_start are always raised together, once per block
  AST_POP_WITH_START: assert property (@(posedge clk) disable iff (rst)
    in_pop == eng_start); // R6
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start); // R6
endmodule

// File: rtl/ctr_mix.sv
module ctr_mix #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             finish,
  input  logic [BLK_W-1:0] in_data,
  input  logic [BLK_W-1:0] eng_out,
  output logic             out_push,
  output logic [BLK_W-1:0] out_data
);
  logic [BLK_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      out_push <= 1'b0;
      out_data <= '0;
    end else begin
      if (capture) word_q <= in_data;
      out_push <= finish;
      if (finish) out_data <= eng_out ^ word_q;
    end
  end

  AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_push |=> !out_push); // R1
endmodule

// File: rtl/ctr_keystream_ctrl.sv
module ctr_keystream_ctrl #(
  parameter int BLK_W = 128,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             dir_decrypt,
  input  logic             ctr_load_en,
  input  logic [BLK_W-1:0] ctr_load_val,
  output logic [BLK_W-1:0] ctr_value,
  input  logic             in_empty,
  input  logic [BLK_W-1:0] in_data,
  output logic             in_pop,
  input  logic             out_full,
  output logic             out_push,
  output logic [BLK_W-1:0] out_data,
  output logic             eng_start,
  output logic [BLK_W-1:0] eng_in,
  input  logic             eng_done,
  input  logic [BLK_W-1:0] eng_out
);
  logic capture, finish, ctr_inc, busy, load_ok;
  logic dir_unused;

  assign dir_unused = dir_decrypt;
  assign load_ok    = ctr_load_en && !enable && !busy;
  assign eng_in     = ctr_value;

  ctr_seq i_seq (
    .clk(clk), .rst(rst), .enable(enable), .in_empty(in_empty),
    .out_full(out_full), .eng_done(eng_done), .capture(capture),
    .finish(finish), .in_pop(in_pop), .eng_start(eng_start),
    .ctr_inc(ctr_inc), .busy(busy)
  );

  ctr_block_reg #(.BLK_W(BLK_W), .CNT_W(CNT_W)) i_ctr (
    .clk(clk), .rst(rst), .load(load_ok), .load_val(ctr_load_val),
    .inc(ctr_inc), .value(ctr_value)
  );

  ctr_mix #(.BLK_W(BLK_W)) i_mix (
    .clk(clk), .rst(rst), .capture(capture), .finish(finish),
    .in_data(in_data), .eng_out(eng_out), .out_push(out_push),
    .out_data(out_data)
  );

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    out_push |=> ctr_value[CNT_W-1:0] == $past(ctr_value[CNT_W-1:0]) + 1'b1); // R3
  AST_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    out_push |=> ctr_value[BLK_W-1:CNT_W] == $past(ctr_value[BLK_W-1:CNT_W])); // R4
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!out_push && !ctr_load_en) |=> $stable(ctr_value)); // R7
  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (ctr_load_en && enable && !out_push) |=> $stable(ctr_value)); // R8
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(enable && !in_empty && !out_full)); // R6
endmodule

// File: tb/test_ctr_keystream_ctrl.sv
module test_ctr_keystream_ctrl;
  localparam int W = 128;
  localparam int LAT = 5;
  localparam logic [W-1:0] ICB = 128'hA5A5_0001_C3C3_0002_1234_5678_FFFF_FFFA;
  // bit 128 = dir_decrypt, bits 127:0 = input word
  localparam logic [W:0] VEC [8] = '{
    {1'b0, 128'h0000_0000_0000_0000_0000_0000_0000_0000},
    {1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    {1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
    {1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
    {1'b0, 128'h8000_0000_0000_0000_0000_0000_0000_0001},
    {1'b1, 128'hDEAD_BEEF_CAFE_F00D_0BAD_F00D_1357_9BDF},
    {1'b0, 128'h5555_AAAA_5555_AAAA_3333_CCCC_0F0F_F0F0},
    {1'b1, 128'h0000_0001_0000_0002_0000_0003_0000_0004}
  };

  logic clk = 0, rst = 1, enable = 0, dir_decrypt = 0, ctr_load_en = 0;
  logic [W-1:0] ctr_load_val = '0, in_data = '0, eng_out, ctr_value, out_data, eng_in;
  logic in_empty = 1, out_full = 0, in_pop, out_push, eng_start, eng_done;
  int checks = 0, fails = 0;
  logic [W-1:0] model_ctr;

  always #2 clk = ~clk;

  function automatic logic [W-1:0] cipher(input logic [W-1:0] x);
    return {x[114:0], x[127:115]} ^ {x[63:0], ~x[127:64]} ^
           128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
  endfunction

  // stand-in engine with fixed latency
  logic [W-1:0] eng_blk;
  int eng_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_cnt <= 0; eng_done <= 1'b0; eng_out <= '0; eng_blk <= '0;
    end else begin
      eng_done <= 1'b0;
      if (eng_start) begin
        eng_blk <= eng_in; eng_cnt <= LAT;
      end else if (eng_cnt > 0) begin
        eng_cnt <= eng_cnt - 1;
        if (eng_cnt == 1) begin
          eng_done <= 1'b1; eng_out <= cipher(eng_blk);
        end
      end
    end
  end

  ctr_keystream_ctrl i_ctr_keystream_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .dir_decrypt(dir_decrypt),
    .ctr_load_en(ctr_load_en), .ctr_load_val(ctr_load_val), .ctr_value(ctr_value),
    .in_empty(in_empty), .in_data(in_data), .in_pop(in_pop),
    .out_full(out_full), .out_push(out_push), .out_data(out_data),
    .eng_start(eng_start), .eng_in(eng_in), .eng_done(eng_done), .eng_out(eng_out)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_ctr(input logic [W-1:0] v);
    @(negedge clk); ctr_load_val = v; ctr_load_en = 1;
    @(negedge clk); ctr_load_en = 0;
  endtask

  task automatic run_block(input logic [W-1:0] word, input logic dir, input string req);
    logic [W-1:0] exp;
    exp = cipher(model_ctr) ^ word;
    @(negedge clk); in_data = word; dir_decrypt = dir; in_empty = 0;
    do @(negedge clk); while (!in_pop);
    check("R2/R6 eng_in", eng_in, model_ctr);
    check("R6 start with pop", {127'd0, eng_start}, 128'd1);
    in_empty = 1;
    do @(negedge clk); while (!out_push);
    check(req, out_data, exp);
    @(negedge clk);
    model_ctr = {model_ctr[127:32], model_ctr[31:0] + 32'd1};
    check("R3 counter step", ctr_value, model_ctr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] saved, alt_out1, alt_out2;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 ctr_value", ctr_value, '0);
    check("R9 strobes", {125'd0, out_push, in_pop, eng_start}, '0);
    rst = 0;
    load_ctr(ICB);
    model_ctr = ICB;
    check("R2 loaded", ctr_value, ICB);
    @(negedge clk); enable = 1;
    // table walk; R4 wrap happens at row 6, R5 dir alternates
    for (int i = 0; i < 8; i++)
      run_block(VEC[i][W-1:0], VEC[i][W], "R1/R5 output word");
    check("R4 upper kept", ctr_value[127:32], ICB[127:32]);
    check("R4 wrapped low", {96'd0, ctr_value[31:0]}, 128'd2);

    // R6: full output FIFO blocks start
    @(negedge clk); out_full = 1; in_data = 128'h77; in_empty = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (in_pop || eng_start) check("R6 stall on full", 128'd1, 128'd0);
    end
    check("R6 counter held on stall", ctr_value, model_ctr);
    out_full = 0; in_empty = 1;
    run_block(128'h77, 1'b0, "R1 after full stall");

    // R6: enable low blocks start
    @(negedge clk); enable = 0; in_empty = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (in_pop || eng_start) check("R6 stall on disable", 128'd1, 128'd0);
    end
    check("R6 counter held disabled", ctr_value, model_ctr);
    in_empty = 1;

    // R8: load while enabled ignored
    @(negedge clk); enable = 1;
    load_ctr(128'h1111_2222_3333_4444_5555_6666_7777_8888);
    check("R8 load ignored", ctr_value, model_ctr);

    // R5: same counter, both directions, same output
    @(negedge clk); enable = 0;
    saved = model_ctr;
    run_block_dir_pair(saved, alt_out1, alt_out2);
    check("R5 dir no effect", alt_out1, alt_out2);

    // R7: suspend, foreign load, resume
    @(negedge clk); enable = 0;
    saved = ctr_value;
    check("R7 readback", saved, model_ctr);
    load_ctr(128'hFEED_0000_0000_0000_0000_0000_0000_0000);
    model_ctr = 128'hFEED_0000_0000_0000_0000_0000_0000_0000;
    @(negedge clk); enable = 1;
    run_block(128'h42, 1'b0, "R1 foreign stream");
    @(negedge clk); enable = 0;
    load_ctr(saved);
    model_ctr = saved;
    check("R7 restored", ctr_value, saved);
    @(negedge clk); enable = 1;
    run_block(128'h9999, 1'b1, "R7 resumed stream");

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic run_block_dir_pair(input logic [W-1:0] c, output logic [W-1:0] o1,
                                    output logic [W-1:0] o2);
    load_ctr(c); model_ctr = c;
    @(negedge clk); enable = 1;
    run_block(128'hABCD, 1'b0, "R5 dir=0");
    o1 = out_data;
    @(negedge clk); enable = 0;
    load_ctr(c); model_ctr = c;
    @(negedge clk); enable = 1;
    run_block(128'hABCD, 1'b1, "R5 dir=1");
    o2 = out_data;
  endtask
endmodule